// File: doc/BRIEF.md
# Pulse Width, Period and Edge Count Capture Timer

This block measures a digital input in units of its own clock. A small set of input pins is brought into the clock domain through a synchronizer chain, and one of them is chosen for the measurement. A single counter and a single capture register serve four measurement kinds. The first is the length of time the pin stays in its asserted level, and the asserted level can be high or low. The second is the spacing between two edges of the same direction. The third is a running tally of edges. The fourth is a tally of edges that stops when a companion timer signals that it has run out.

Software or a sequencer sets the mode inputs and pulses `start`. The block samples its configuration on that strobe and then waits for the input activity. In the capture modes it freezes the measurement in `result` and raises `done`. `done` stays high until the next `start`. The counter saturates at its all-ones value, and a sticky `overflow` flag then records that the true value was larger. The input may change at most once every two clock cycles, so its frequency must stay at or below one quarter of the clock.

Top module: `pulse_capture_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `result` is 0, `done` is 0 and `overflow` is 0 until a `start` strobe arrives.
- R2: Each pin of `pin_in` passes through a two-stage synchronizer. `pin_sel` (binary index, sampled at `start`) chooses the measured pin, and activity on the unselected pin leaves `result` unchanged.
- R3: With `mode`=0 (width), the block waits for the pin to enter its asserted level and then counts the clock cycles for which it stays there. `active_low`=0 means that high is asserted and `active_low`=1 means that low is asserted. The count is captured when the pin leaves that level.
- R4: With `mode`=1 (period), the block waits for an edge of the selected kind (`edge_sel`=0 rising, 1 falling) and then counts clock cycles until the next edge of the same kind. That count is captured.
- R5: With `mode`=2 (free count), the block counts input edges of the selected kind (`edge_sel`=0 rising, 1 falling, 2 or 3 both). `result` follows the running count, and `done` stays 0.
- R6: With `mode`=3 (windowed), the block counts the selected edges until a one-cycle `win_underflow` pulse arrives. It then captures the count and raises `done`, and any later edges leave `result` unchanged.
- R7: The counter saturates at 65535 (all ones of `CNT_W`). An increment attempted at that value sets `overflow`, which stays set until the next `start`.
- R8: After a capture, `done` and `result` hold until `start`. The cycle after a `start` strobe shows `done`=0, `overflow`=0 and `result`=0, and a new measurement begins.
- R9: `win_underflow` has no effect unless a windowed measurement is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw asynchronous input pins |
| pin_sel | input | SEL_W | Index of the pin to measure |
| mode | input | 2 | 0 width, 1 period, 2 free count, 3 windowed count |
| edge_sel | input | 2 | 0 rising, 1 falling, 2/3 both |
| active_low | input | 1 | Asserted level is low when set |
| win_underflow | input | 1 | Underflow strobe from the companion window timer |
| start | input | 1 | Starts a new measurement and samples the configuration |
| result | output | CNT_W | Captured or running measurement |
| done | output | 1 | Measurement complete, held until next start |
| overflow | output | 1 | Counter saturated during this measurement |

## Verification
On every cycle the embedded properties check that `done` and `result` hold between a capture and the next `start`. They also check that `start` clears the flags, that a saturated counter stays saturated, that `overflow` is sticky, and that an underflow during a windowed run ends that run. The correctness of the measured numbers can only be shown by the bench's scenarios. These are pulse widths under both polarities, edge spacing for each edge direction, edge tallies under each edge choice, window boundaries and the saturation case, all compared with values the bench derives from the waveforms it drives.

// File: rtl/captmr_pkg.sv
package captmr_pkg;

   typedef enum logic [1:0] {
      M_WIDTH  = 2'd0,
      M_PERIOD = 2'd1,
      M_COUNT  = 2'd2,
      M_WINDOW = 2'd3
   } meas_mode_e;

   typedef enum logic [1:0] {
      E_RISE = 2'd0,
      E_FALL = 2'd1,
      E_BOTH = 2'd2,
      E_ANY  = 2'd3
   } edge_kind_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ARM  = 2'd1,
      S_RUN  = 2'd2,
      S_DONE = 2'd3
   } ctl_state_e;

endpackage

// File: rtl/captmr_sync.sv
module captmr_sync #(
   parameter int NUM_PINS = 2,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_now,
   output logic [NUM_PINS-1:0] pin_old
);

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], pin_raw[g]};
            last  <= chain[STAGES-1];
         end
      end

      assign pin_now[g] = chain[STAGES-1];
      assign pin_old[g] = last;
   end

endmodule

// File: rtl/captmr_edge.sv
module captmr_edge
   import captmr_pkg::*;
#(
   parameter int NUM_PINS = 2,
   parameter int SEL_W    = 1
) (
   input  logic [NUM_PINS-1:0] pin_now,
   input  logic [NUM_PINS-1:0] pin_old,
   input  logic [SEL_W-1:0]    sel,
   input  edge_kind_e          kind,
   input  logic                low_true,
   output logic                lvl,
   output logic                lvl_entry,
   output logic                hit
);

   logic cur_s, old_s, rise, fall;

   always_comb begin
      cur_s = 1'b0;
      old_s = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (32'(sel) == i) begin
            cur_s = pin_now[i];
            old_s = pin_old[i];
         end
      end
   end

   assign rise      = cur_s & ~old_s;
   assign fall      = ~cur_s & old_s;
   assign lvl       = cur_s ^ low_true;
   assign lvl_entry = lvl & ~(old_s ^ low_true);

   always_comb begin
      unique case (kind)
         E_RISE:  hit = rise;
         E_FALL:  hit = fall;
         default: hit = rise | fall;
      endcase
   end

endmodule

// File: rtl/captmr_ctrl.sv
module captmr_ctrl
   import captmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode_in,
   input  logic [1:0]       kind_in,
   input  logic             low_in,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             lvl,
   input  logic             lvl_entry,
   input  logic             hit,
   input  logic             win_uf,
   output edge_kind_e       cfg_kind,
   output logic             cfg_low,
   output logic [SEL_W-1:0] cfg_sel,
   output logic [CNT_W-1:0] result,
   output logic             done,
   output logic             overflow
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   meas_mode_e       cfg_mode;
   ctl_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] inc_val;
   logic             at_max;
   logic             arm_go;

   assign at_max  = (cnt == CNT_MAX);
   assign inc_val = at_max ? CNT_MAX : cnt + CNT_ONE;
   assign arm_go  = (cfg_mode == M_WIDTH) ? lvl_entry : hit;
   assign done    = (state == S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode <= M_WIDTH;
         cfg_kind <= E_RISE;
         cfg_low  <= 1'b0;
         cfg_sel  <= '0;
         state    <= S_IDLE;
         cnt      <= '0;
         result   <= '0;
         overflow <= 1'b0;
      end else if (start) begin
         cfg_mode <= meas_mode_e'(mode_in);
         cfg_kind <= edge_kind_e'(kind_in);
         cfg_low  <= low_in;
         cfg_sel  <= sel_in;
         cnt      <= '0;
         result   <= '0;
         overflow <= 1'b0;
         if (mode_in == M_WIDTH || mode_in == M_PERIOD) state <= S_ARM;
         else                                             state <= S_RUN;
      end else begin
         unique case (state)
            S_ARM: begin
               if (arm_go) begin
                  state <= S_RUN;
                  cnt   <= (cfg_mode == M_WIDTH) ? CNT_ONE : '0;
               end
            end
            S_RUN: begin
               unique case (cfg_mode)
                  M_WIDTH: begin
                     if (lvl) begin
                        cnt      <= inc_val;
                        overflow <= overflow | at_max;
                     end else begin
                        result <= cnt;
                        state  <= S_DONE;
                     end
                  end
                  M_PERIOD: begin
                     overflow <= overflow | at_max;
                     if (hit) begin
                        result <= inc_val;
                        state  <= S_DONE;
                     end else begin
                        cnt <= inc_val;
                     end
                  end
                  M_COUNT: begin
                     if (hit) begin
                        cnt      <= inc_val;
                        result   <= inc_val;
                        overflow <= overflow | at_max;
                     end
                  end
                  default: begin
                     if (hit) begin
                        cnt      <= inc_val;
                        overflow <= overflow | at_max;
                     end
                     if (win_uf) begin
                        result <= hit ? inc_val : cnt;
                        state  <= S_DONE;
                     end
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   // R8: a finished measurement stays finished until restarted
   a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R8: the captured value does not move while done
   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(result));

   // R8: start always clears the flags
   a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !overflow && result == '0));

   // R7: a saturated counter never wraps
   a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && at_max && !start) |=> (cnt == CNT_MAX));

   // R7: overflow is sticky within a measurement
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !start) |=> overflow);

   // R6: an underflow during a windowed run ends it
   a_r6_window_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && cfg_mode == M_WINDOW && win_uf && !start) |=> done);

endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
   import captmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [SEL_W-1:0]    pin_sel,
   input  logic [1:0]          mode,
   input  logic [1:0]          edge_sel,
   input  logic                active_low,
   input  logic                win_underflow,
   input  logic                start,
   output logic [CNT_W-1:0]    result,
   output logic                done,
   output logic                overflow
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_now, pin_old;
   edge_kind_e          cfg_kind;
   logic                cfg_low;
   logic [SEL_W-1:0]    cfg_sel;
   logic                lvl, lvl_entry, hit;

   captmr_sync #(
      .NUM_PINS (NUM_PINS),
      .STAGES   (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (pin_in),
      .pin_now (pin_now),
      .pin_old (pin_old)
   );

   captmr_edge #(
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W)
   ) u_edge (
      .pin_now   (pin_now),
      .pin_old   (pin_old),
      .sel       (cfg_sel),
      .kind      (cfg_kind),
      .low_true  (cfg_low),
      .lvl       (lvl),
      .lvl_entry (lvl_entry),
      .hit       (hit)
   );

   captmr_ctrl #(
      .CNT_W (CNT_W),
      .SEL_W (SEL_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode_in   (mode),
      .kind_in   (edge_sel),
      .low_in    (active_low),
      .sel_in    (pin_sel),
      .lvl       (lvl),
      .lvl_entry (lvl_entry),
      .hit       (hit),
      .win_uf    (win_underflow),
      .cfg_kind  (cfg_kind),
      .cfg_low   (cfg_low),
      .cfg_sel   (cfg_sel),
      .result    (result),
      .done      (done),
      .overflow  (overflow)
   );

endmodule

// File: tb/sim_pulse_capture_timer.sv
module sim_pulse_capture_timer;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 180000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  pin_in = 2'b00;
   logic [0:0]  pin_sel = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [1:0]  edge_sel = 2'd0;
   logic        active_low = 1'b0;
   logic        win_underflow = 1'b0;
   logic        start = 1'b0;
   logic [15:0] result;
   logic        done;
   logic        overflow;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_capture_timer u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
      .mode(mode), .edge_sel(edge_sel), .active_low(active_low),
      .win_underflow(win_underflow), .start(start),
      .result(result), .done(done), .overflow(overflow)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(input logic [1:0] m, input logic [1:0] e,
                           input logic pol, input logic sel);
      mode = m; edge_sel = e; active_low = pol; pin_sel = sel;
      start = 1'b1;
      tick(1);
      start = 1'b0;
   endtask

   function automatic int expect_edges(int rises, int falls, logic [1:0] e);
      if (e == 2'd0) return rises;
      if (e == 2'd1) return falls;
      return rises + falls;
   endfunction

   function automatic int clamp16(int v);
      return (v > 65535) ? 65535 : v;
   endfunction

   // drives nseg toggles on pin p, each level held 2..4 cycles
   task automatic toggles(input int p, input int nseg, output int rises, output int falls);
      rises = 0; falls = 0;
      for (int i = 0; i < nseg; i++) begin
         if (pin_in[p]) falls++; else rises++;
         pin_in[p] = ~pin_in[p];
         tick(2 + int'($urandom % 3));
      end
   endtask

   task automatic width_run(input string req, input int n, input logic pol);
      pin_in[0] = pol;
      tick(5);
      do_start(2'd0, 2'd0, pol, 1'b0);
      tick(3);
      pin_in[0] = ~pol;
      tick(n);
      pin_in[0] = pol;
      tick(6);
      check({req, " done"}, 32'(done), 1);
      check({req, " width"}, 32'(result), 32'(clamp16(n)));
   endtask

   task automatic period_run(input string req, input int h, input int l, input logic [1:0] e);
      pin_in[0] = 1'b0;
      tick(5);
      do_start(2'd1, e, 1'b0, 1'b0);
      tick(3);
      for (int k = 0; k < 3; k++) begin
         pin_in[0] = 1'b1; tick(h);
         pin_in[0] = 1'b0; tick(l);
      end
      tick(4);
      check({req, " done"}, 32'(done), 1);
      check({req, " period"}, 32'(result), 32'(h + l));
   endtask

   task automatic count_run(input string req, input int nseg, input logic [1:0] e);
      int r, f;
      pin_in[0] = 1'b0;
      tick(5);
      do_start(2'd2, e, 1'b0, 1'b0);
      tick(3);
      toggles(0, nseg, r, f);
      tick(5);
      check({req, " count"}, 32'(result), 32'(expect_edges(r, f, e)));
      check({req, " no done"}, 32'(done), 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      int r, f, rr, ff, hold_res;
      void'($urandom(32'd20251));
      tick(3);
      // R1: values during and after reset
      check("R1 result in reset", 32'(result), 0);
      check("R1 done in reset", 32'(done), 0);
      rst_n = 1'b1;
      tick(4);
      check("R1 result after reset", 32'(result), 0);
      check("R1 done after reset", 32'(done), 0);
      check("R1 overflow after reset", 32'(overflow), 0);

      // R3: directed widths, both polarities
      width_run("R3 hi w1", 1, 1'b0);
      width_run("R3 hi w7", 7, 1'b0);
      width_run("R3 lo w5", 5, 1'b1);

      // R8: hold and restart
      tick(10);
      check("R8 done held", 32'(done), 1);
      check("R8 result held", 32'(result), 5);
      do_start(2'd0, 2'd0, 1'b0, 1'b0);
      check("R8 start clears done", 32'(done), 0);
      check("R8 start clears result", 32'(result), 0);

      // R9: underflow ignored outside a windowed run
      pin_in[0] = 1'b0;
      tick(3);
      win_underflow = 1'b1; tick(1); win_underflow = 1'b0;
      tick(5);
      check("R9 underflow ignored", 32'(done), 0);
      pin_in[0] = 1'b1; tick(4); pin_in[0] = 1'b0; tick(6);
      check("R9 width still measured", 32'(result), 4);

      // R4: period with rising and falling edges
      period_run("R4 rise", 3, 5, 2'd0);
      period_run("R4 fall", 6, 2, 2'd1);

      // R5: edge counting under each selection
      count_run("R5 rise", 9, 2'd0);
      count_run("R5 fall", 8, 2'd1);
      count_run("R5 both", 11, 2'd2);

      // R2: unselected pin has no effect, pin 1 can be measured
      pin_in = 2'b00;
      tick(5);
      do_start(2'd2, 2'd2, 1'b0, 1'b0);
      tick(3);
      toggles(1, 6, r, f);
      tick(5);
      check("R2 other pin ignored", 32'(result), 0);
      pin_in = 2'b00;
      tick(5);
      do_start(2'd2, 2'd0, 1'b0, 1'b1);
      tick(3);
      toggles(1, 7, r, f);
      tick(5);
      check("R2 pin 1 measured", 32'(result), 32'(r));

      // R6: windowed count, later edges ignored
      pin_in = 2'b00;
      tick(5);
      do_start(2'd3, 2'd2, 1'b0, 1'b0);
      tick(3);
      toggles(0, 10, r, f);
      tick(5);
      check("R6 not done before window end", 32'(done), 0);
      win_underflow = 1'b1; tick(1); win_underflow = 1'b0;
      tick(3);
      check("R6 done at window end", 32'(done), 1);
      check("R6 window count", 32'(result), 32'(r + f));
      hold_res = int'(result);
      toggles(0, 6, rr, ff);
      tick(5);
      check("R6 later edges ignored", 32'(result), 32'(hold_res));

      // random mix
      for (int i = 0; i < 6; i++) begin
         int w = 1 + int'($urandom % 40);
         logic p = 1'($urandom % 2);
         width_run("R3 random", w, p);
         period_run("R4 random", 2 + int'($urandom % 9), 2 + int'($urandom % 9),
                    2'($urandom % 2));
         count_run("R5 random", 1 + int'($urandom % 20), 2'($urandom % 4));
      end

      // R7: saturation in width mode
      width_run("R7 saturate", 65540, 1'b0);
      check("R7 overflow set", 32'(overflow), 1);
      do_start(2'd2, 2'd0, 1'b0, 1'b0);
      check("R7 R8 start clears overflow", 32'(overflow), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule